// File: doc/BRIEF.md
# Sample-Hold Refresh Sequencer

This block keeps a set of analog control voltages alive on hold capacitors that share one 12-bit DAC and an 8-way analog multiplexer. A host stores one 12-bit target code per channel. Code 0 maps to -5 V and code 4095 maps to +5 V. On every refresh tick the block takes the next channel in rotation. It copies that channel's code and then produces four bus writes in a fixed order:

1. Set the multiplexer inhibit.
2. Write the channel address and the low four code bits into the mux-control latch.
3. Drive the upper eight code bits onto the DAC data port and give the DAC a strobe.
4. Release the inhibit, so the selected hold amplifier settles to the new voltage.

The refresh tick comes from an internal divider. Its default is 2 ms at a 10 MHz clock. A square-wave-select input forces the square-amplitude channel to code 0 (-5 V) while it is low. The stored code is not touched. The analog parts and any calibration arithmetic sit outside this block.

Top module: `shr_refresh_seq`

## Requirements
- R1: A host write with `host_we` high stores `host_code` as the code of channel `host_ch`. After reset every channel code is 2048.
- R2: The first write of a refresh sets latch bit 7 (the mux inhibit) to 1 and leaves bits 6:0 unchanged.
- R3: The second write sets the latch to {1, channel index as a 3-bit address in bits 6:4, code bits 3:0 in bits 3:0}.
- R4: The third write drives code bits 11:4 on `dac_data`. `dac_stb_n` is low for exactly one clock, the clock at offset HOLD_CLKS/2 of that write, while the inhibit is high.
- R5: The fourth write clears latch bit 7 and keeps bits 6:0.
- R6: Each tick refreshes exactly one channel, in the order 0, 1, 2, 3, 0, and so on. Outside a refresh no bus write occurs.
- R7: Refreshes start every TICK_DIV clocks (2 ms at the default clock rate).
- R8: While `sq_sel` is low, channel 1 (square amplitude) is refreshed with code 0. The stored code is kept and is used again once `sq_sel` is high.
- R9: Each of the four writes is held for HOLD_CLKS clocks before the next one.
- R10: A refresh uses the code and `sq_sel` as sampled at its start. A host write that lands during that channel's refresh shows up only at the channel's next refresh.
- R11: After reset the latch reads 0x80, `dac_data` is 0, `dac_stb_n` is high, and rotation starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host code write enable |
| host_ch | input | 2 | Channel selected by a host write |
| host_code | input | 12 | Code written by the host |
| sq_sel | input | 1 | Square wave selected; low forces channel 1 to code 0 |
| mux_latch | output | 8 | Mux-control latch word: inhibit, address, code LSBs |
| dac_data | output | 8 | DAC data port carrying code bits 11:4 |
| dac_stb_n | output | 1 | Active-low one-clock DAC load strobe |

## Verification
A host write to a channel and the start of that same channel's refresh can fall in the same cycle, or within its four writes. The bench provokes this by waiting until the inhibit bit rises for channel 2 and then writing a new code. It expects the old code on the DAC port in that refresh and the new code one rotation later. A scoreboard compares every latch change and every strobe against predicted words, spacings and tick period.

// File: rtl/shr_pkg.sv
package shr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_INHIBIT,
      PH_ADDR,
      PH_LOAD,
      PH_RELEASE
   } shr_phase_e;
endpackage

// File: rtl/shr_tick_gen.sv
module shr_tick_gen #(
   parameter int TICK_DIV = 20000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = $clog2(TICK_DIV);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == CNT_W'(TICK_DIV - 1)) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   // R7: the tick is a single-clock pulse
   assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/shr_code_bank.sv
module shr_code_bank #(
   parameter int NUM_CH      = 4,
   parameter int CODE_W      = 12,
   parameter int CH_W        = 2,
   parameter int RESET_CODE  = 2048,
   parameter int SQ_CH       = 1,
   parameter bit SQ_FORCE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              sq_sel,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [CODE_W-1:0] rd_code
);
   logic [CODE_W-1:0] regs [NUM_CH];
   logic [CODE_W-1:0] picked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) regs[i] <= CODE_W'(RESET_CODE);
      end else if (wr_en) begin
         for (int i = 0; i < NUM_CH; i++)
            if (wr_ch == CH_W'(i)) regs[i] <= wr_code;
      end
   end

   assign picked = regs[rd_ch];

   generate
      if (SQ_FORCE_EN) begin : g_force
         assign rd_code = (!sq_sel && rd_ch == CH_W'(SQ_CH)) ? '0 : picked;

         // R8: forced channel reads zero while the square wave is off
         assert_force_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!sq_sel && rd_ch == CH_W'(SQ_CH)) |-> rd_code == '0);
      end else begin : g_plain
         assign rd_code = picked;
      end
   endgenerate
endmodule

// File: rtl/shr_write_seq.sv
module shr_write_seq
   import shr_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int CODE_W    = 12,
   parameter int CH_W      = 2,
   parameter int ADDR_W    = 3,
   parameter int LSB_W     = 4,
   parameter int HOLD_CLKS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   output logic [CH_W-1:0]         rd_ch,
   input  logic [CODE_W-1:0]       rd_code,
   output logic [ADDR_W+LSB_W:0]   mux_latch,
   output logic [CODE_W-LSB_W-1:0] dac_data,
   output logic                    dac_stb_n
);
   localparam int LATCH_W = 1 + ADDR_W + LSB_W;
   localparam int HOLD_W  = $clog2(HOLD_CLKS);
   localparam int MID     = HOLD_CLKS / 2;

   shr_phase_e        phase;
   logic [HOLD_W-1:0] hold_cnt;
   logic [CH_W-1:0]   ch_ptr;
   logic [CH_W-1:0]   snap_ch;
   logic [CODE_W-1:0] snap_code;
   logic              hold_done;

   assign rd_ch     = ch_ptr;
   assign hold_done = (hold_cnt == HOLD_W'(HOLD_CLKS - 1));
   assign dac_stb_n = !(phase == PH_LOAD && hold_cnt == HOLD_W'(MID));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         hold_cnt  <= '0;
         ch_ptr    <= '0;
         snap_ch   <= '0;
         snap_code <= '0;
         mux_latch <= LATCH_W'(1) << (LATCH_W - 1);
         dac_data  <= '0;
      end else if (phase == PH_IDLE) begin
         if (tick) begin
            snap_code <= rd_code;
            snap_ch   <= ch_ptr;
            ch_ptr    <= (ch_ptr == CH_W'(NUM_CH - 1)) ? '0 : ch_ptr + 1'b1;
            mux_latch[LATCH_W-1] <= 1'b1;
            hold_cnt  <= '0;
            phase     <= PH_INHIBIT;
         end
      end else if (!hold_done) begin
         hold_cnt <= hold_cnt + 1'b1;
      end else begin
         hold_cnt <= '0;
         unique case (phase)
            PH_INHIBIT: begin
               mux_latch <= {1'b1, ADDR_W'(snap_ch), snap_code[LSB_W-1:0]};
               phase     <= PH_ADDR;
            end
            PH_ADDR: begin
               dac_data <= snap_code[CODE_W-1:LSB_W];
               phase    <= PH_LOAD;
            end
            PH_LOAD: begin
               mux_latch[LATCH_W-1] <= 1'b0;
               phase <= PH_RELEASE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R2: a tick seen while idle raises the inhibit on the next clock
   assert_tick_inhibits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && phase == PH_IDLE) |=> mux_latch[LATCH_W-1]);
   // R4: strobe lasts one clock
   assert_stb_one_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_stb_n |=> dac_stb_n);
   // R4: DAC loads only while the mux is inhibited
   assert_stb_inhibited_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_stb_n |-> mux_latch[LATCH_W-1]);
   // R4: data settled before the strobe
   assert_dac_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_stb_n |-> $stable(dac_data));
   // R5: release keeps address and low bits
   assert_release_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mux_latch[LATCH_W-1]) |-> mux_latch[LATCH_W-2:0] == $past(mux_latch[LATCH_W-2:0]));
endmodule

// File: rtl/shr_refresh_seq.sv
module shr_refresh_seq #(
   parameter int NUM_CH      = 4,
   parameter int CODE_W      = 12,
   parameter int LSB_W       = 4,
   parameter int ADDR_W      = 3,
   parameter int HOLD_CLKS   = 4,
   parameter int TICK_DIV    = 20000,
   parameter int RESET_CODE  = 2048,
   parameter int SQ_CH       = 1,
   parameter bit SQ_FORCE_EN = 1'b1,
   localparam int CH_W       = $clog2(NUM_CH),
   localparam int DAC_W      = CODE_W - LSB_W,
   localparam int LATCH_W    = 1 + ADDR_W + LSB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [CH_W-1:0]   host_ch,
   input  logic [CODE_W-1:0] host_code,
   input  logic              sq_sel,
   output logic [LATCH_W-1:0] mux_latch,
   output logic [DAC_W-1:0]  dac_data,
   output logic              dac_stb_n
);
   generate
      if (NUM_CH < 2 || NUM_CH > (1 << ADDR_W))
         $error("NUM_CH must fit the mux address");
      if (CODE_W <= LSB_W)
         $error("CODE_W must exceed LSB_W");
      if (HOLD_CLKS < 2)
         $error("HOLD_CLKS must be at least 2");
      if (TICK_DIV <= 4 * HOLD_CLKS + 1)
         $error("TICK_DIV must cover a full write sequence");
      if (SQ_CH >= NUM_CH)
         $error("SQ_CH out of range");
   endgenerate

   logic              tick;
   logic [CH_W-1:0]   rd_ch;
   logic [CODE_W-1:0] rd_code;

   shr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   shr_code_bank #(
      .NUM_CH(NUM_CH), .CODE_W(CODE_W), .CH_W(CH_W),
      .RESET_CODE(RESET_CODE), .SQ_CH(SQ_CH), .SQ_FORCE_EN(SQ_FORCE_EN)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (host_we),
      .wr_ch   (host_ch),
      .wr_code (host_code),
      .sq_sel  (sq_sel),
      .rd_ch   (rd_ch),
      .rd_code (rd_code)
   );

   shr_write_seq #(
      .NUM_CH(NUM_CH), .CODE_W(CODE_W), .CH_W(CH_W),
      .ADDR_W(ADDR_W), .LSB_W(LSB_W), .HOLD_CLKS(HOLD_CLKS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rd_ch     (rd_ch),
      .rd_code   (rd_code),
      .mux_latch (mux_latch),
      .dac_data  (dac_data),
      .dac_stb_n (dac_stb_n)
   );
endmodule

// File: tb/shr_refresh_seq_tb.sv
module shr_refresh_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TICK       = 64;
   localparam int HOLD       = 4;
   localparam int MID        = HOLD / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_ch = '0;
   logic [11:0] host_code = '0;
   logic        sq_sel = 1'b1;
   logic [7:0]  mux_latch;
   logic [7:0]  dac_data;
   logic        dac_stb_n;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shr_refresh_seq #(.HOLD_CLKS(HOLD), .TICK_DIV(TICK)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_ch(host_ch),
      .host_code(host_code), .sq_sel(sq_sel), .mux_latch(mux_latch),
      .dac_data(dac_data), .dac_stb_n(dac_stb_n)
   );

   typedef struct {
      bit         is_dac;
      logic [7:0] val;
      int         gap;
      int         req;
   } exp_t;

   exp_t        expq[$];
   int          n_chk = 0;
   int          n_fail = 0;
   logic [11:0] codes [4];
   logic [7:0]  model_latch;
   logic [7:0]  prev_latch;
   int          since = 0;
   int          cyc = 0;
   int          last_rise = -1;
   int          cand;
   bit          mon_on = 1'b0;

   task automatic check(input bit ok, input int req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input bit d, input logic [7:0] v, input int g, input int r);
      exp_t e;
      e.is_dac = d; e.val = v; e.gap = g; e.req = r;
      expq.push_back(e);
   endtask

   // Driver: predicts the four writes of one refresh (R2 R3 R4 R5 R9)
   task automatic push_refresh(input int ch, input int dac_tag);
      logic [11:0] code;
      logic [7:0]  w1, w2, w4;
      bit          c1, c2;
      code = (ch == 1 && !sq_sel) ? 12'h000 : codes[ch];   // R8
      w1 = model_latch | 8'h80;                             // R2
      c1 = (w1 != model_latch);
      if (c1) push(1'b0, w1, -1, 2);
      model_latch = w1;
      w2 = {1'b1, 3'(ch), code[3:0]};                       // R3
      c2 = (w2 != model_latch);
      if (c2) push(1'b0, w2, c1 ? HOLD : -1, 3);
      model_latch = w2;
      push(1'b1, code[11:4], c2 ? HOLD + MID : -1, dac_tag); // R4
      w4 = w2 & 8'h7f;                                      // R5
      push(1'b0, w4, c2 ? 2 * HOLD : -1, 5);
      model_latch = w4;
   endtask

   task automatic take(input bit d, input logic [7:0] v, input int g);
      exp_t e;
      if (expq.size() == 0) begin
         check(1'b0, 6, "unexpected bus write", v, 0);      // R6
      end else begin
         e = expq.pop_front();
         check(e.is_dac == d, e.req, "write kind", d, e.is_dac);
         check(e.val == v, e.req, d ? "dac data" : "latch word", v, e.val);
         if (e.gap >= 0) check(g == e.gap, 9, "write spacing", g, e.gap); // R9
      end
   endtask

   // Monitor
   always @(negedge clk) begin
      cyc++;
      if (!mon_on) begin
         prev_latch = mux_latch;
         since = 0;
      end else begin
         if (mux_latch !== prev_latch) begin
            cand = since + 1;
            take(1'b0, mux_latch, cand);
            since = 0;
            if (mux_latch[7] && !prev_latch[7]) begin
               if (last_rise >= 0)                            // R7
                  check(cyc - last_rise == TICK, 7, "tick spacing", cyc - last_rise, TICK);
               last_rise = cyc;
            end
         end else begin
            since++;
         end
         if (!dac_stb_n) take(1'b1, dac_data, since);
         prev_latch = mux_latch;
      end
   end

   task automatic host_write(input int ch, input logic [11:0] v);
      @(negedge clk);
      host_we = 1'b1; host_ch = 2'(ch); host_code = v;
      @(negedge clk);
      host_we = 1'b0;
      codes[ch] = v;                                        // R1
   endtask

   task automatic wait_end();
      while (!mux_latch[7]) @(negedge clk);
      while (mux_latch[7]) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) codes[i] = 12'd2048;
      model_latch = 8'h80;
      repeat (5) @(negedge clk);
      // R11: reset state
      check(mux_latch == 8'h80, 11, "reset latch", mux_latch, 8'h80);
      check(dac_data == 8'h00, 11, "reset dac data", dac_data, 0);
      check(dac_stb_n == 1'b1, 11, "reset strobe", dac_stb_n, 1);
      push_refresh(0, 11);           // R11: rotation begins at channel 0
      rst_n = 1'b1;
      mon_on = 1'b1;
      wait_end();
      // R1: host writes reach the refreshed codes
      host_write(1, 12'h123);
      host_write(2, 12'hfff);
      host_write(3, 12'h000);
      host_write(0, 12'h7e1);
      for (int k = 1; k <= 4; k++) begin
         push_refresh(k % 4, (k == 4) ? 6 : 1);  // R6 wrap to channel 0
         wait_end();
      end
      // R8: square wave off forces channel 1 to zero
      sq_sel = 1'b0;
      host_write(1, 12'habc);
      push_refresh(1, 8);
      wait_end();
      sq_sel = 1'b1;
      // R10: write during channel 2 refresh is deferred
      push_refresh(2, 10);
      while (!mux_latch[7]) @(negedge clk);
      host_write(2, 12'h5a5);
      while (mux_latch[7]) @(negedge clk);
      push_refresh(3, 6);
      wait_end();
      push_refresh(0, 6);
      wait_end();
      push_refresh(1, 8);            // R8: stored code returns
      wait_end();
      push_refresh(2, 10);           // R10: new code now applied
      wait_end();
      repeat (10) @(negedge clk);
      check(expq.size() == 0, 6, "pending expected writes", expq.size(), 0);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=0x0 expected=0x1");
      summary();
      $finish;
   end
endmodule